// File: doc/BRIEF.md
# CAN End-of-Frame Validation Monitor

This block sits beside the bit-level engine of a CAN controller and decides when a frame becomes valid. Neighbouring logic handles bit timing, destuffing, CRC and arbitration. It passes in one sampled bus level per bit strobe. It also raises a start flag together with the strobe of the first end-of-frame bit, once CRC and acknowledge have completed. The start flag also latches the role the node had in that frame: receiver or transmitter.

The two roles reach validity at different bits of the seven-bit recessive end-of-frame field. A receiver accepts the message at the sample point of the sixth bit, and never after only five recessive bits. A dominant sixth bit is a bus error, and no acceptance is given. A dominant seventh bit is tolerated by a receiver. A transmitter needs all seven bits recessive before it reports success. Any dominant bit it sees in the field causes an error and a retransmission request.

Errors raise a one-cycle error-frame request and update the matching error counter. Receive-side errors add one to the receive counter, which stops at its maximum. Transmit-side errors add eight to the transmit counter, which also stops at its maximum.

The bit stream is a strobe interface without back-pressure. A bit is consumed on every clock edge where `bit_valid_i` is high, and the producer never waits. This matches a bus that cannot be stalled. All result pulses are registered and appear in the cycle after the edge that consumed the bit.

Top module: `can_eof_monitor`

## Requirements
- R1: Out of reset all pulse outputs are low, both error counters read 0 and `eof_active_o` is low.
- R2: In the receiver role (`role_tx_i`=0), a dominant bit (`bit_rec_i`=0) at end-of-frame bit 1 to 5 raises `err_frame_o` for one cycle, adds 1 to `rec_o` and ends the field.
- R3: In the receiver role, `rx_accept_o` pulses for exactly one cycle, in the cycle after the sample of bit 6, when bits 1 to 6 were all recessive. It is never raised for an earlier bit.
- R4: In the receiver role, a dominant bit 6 gives no acceptance, raises `err_frame_o` and adds 1 to `rec_o`.
- R5: In the receiver role, a dominant bit 7 raises no error, leaves both counters unchanged and ends the field.
- R6: In the transmitter role (`role_tx_i`=1), `tx_success_o` pulses for one cycle after the sample of bit 7, only when all seven bits were recessive. `rx_accept_o` never pulses in this role.
- R7: In the transmitter role, a dominant bit at any of positions 1 to 7 raises `tx_retry_o` and `err_frame_o` for one cycle, adds 8 to `tec_o` and ends the field with no success pulse.
- R8: `rec_o` (8 bits) stops at 255 and `tec_o` (9 bits) stops at 511. Neither counter wraps.
- R9: After bit 7, or after an error, the monitor is idle (`eof_active_o`=0). Further strobes without the start flag produce no pulse and leave the counters unchanged.
- R10: A start flag that arrives while a field is in progress restarts counting at bit 1 and takes the newly presented role.
- R11: Cycles with `bit_valid_i` low neither advance the bit position nor produce any pulse. The start flag counts only together with a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_valid_i | input | 1 | Strobe: one sampled bus bit is presented this cycle |
| bit_rec_i | input | 1 | Sampled level, 1 = recessive, 0 = dominant |
| eof_start_i | input | 1 | With the strobe: this bit is end-of-frame bit 1 |
| role_tx_i | input | 1 | Role latched with the start flag, 1 = transmitter |
| rx_accept_o | output | 1 | Receiver accepts the message (one-cycle pulse) |
| tx_success_o | output | 1 | Transmission completed successfully (one-cycle pulse) |
| tx_retry_o | output | 1 | Transmitter requests retransmission (one-cycle pulse) |
| err_frame_o | output | 1 | Bus error, send an error frame (one-cycle pulse) |
| rec_o | output | 8 | Receive error counter |
| tec_o | output | 9 | Transmit error counter |
| eof_active_o | output | 1 | An end-of-frame field is being tracked |

## Verification
Every result of a strobed bit is due one clock edge after the edge that consumed it. That covers each pulse, the counter steps and the change in `eof_active_o`. The bench changes inputs on the falling edge, holds the strobe across exactly one rising edge, and reads all outputs at the following falling edge, when the registered results of that bit are settled. The idle cycles between strobes are checked at their own falling edges and must show no pulse and unchanged counters. The sweep covers both roles with every single dominant position, plus an all-recessive field. It uses a bench-side model that applies steps of one and eight with saturation.

// File: rtl/can_eof_pkg.sv
package can_eof_pkg;

  // Decision taken for one strobed end-of-frame bit.
  typedef struct packed {
    logic accept;   // receiver validation point reached cleanly
    logic done;     // transmitter saw the whole field recessive
    logic rx_err;   // receiver-side bus error
    logic tx_err;   // transmitter-side bus error
    logic finish;   // field is over after this bit
  } eof_verdict_t;

  typedef enum logic {
    ROLE_RX = 1'b0,
    ROLE_TX = 1'b1
  } eof_role_e;

endpackage

// File: rtl/eof_tracker.sv
module eof_tracker #(
  parameter int EOF_BITS = 7,
  parameter int PW       = $clog2(EOF_BITS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_valid,
  input  logic          eof_start,
  input  logic          role_in,
  input  logic          finish,
  output logic          live,
  output logic [PW-1:0] pos,
  output logic          role_cur,
  output logic          active
);

  logic          active_q;
  logic [PW-1:0] pos_q;
  logic          role_q;

  // A start flag always restarts at bit 1, even mid-field.
  assign live     = bit_valid && (eof_start || active_q);
  assign pos      = eof_start ? PW'(1) : pos_q + PW'(1);
  assign role_cur = eof_start ? role_in : role_q;
  assign active   = active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      pos_q    <= '0;
      role_q   <= can_eof_pkg::ROLE_RX;
    end else if (live) begin
      role_q <= role_cur;
      if (finish) begin
        active_q <= 1'b0;
        pos_q    <= '0;
      end else begin
        active_q <= 1'b1;
        pos_q    <= pos;
      end
    end
  end

endmodule

// File: rtl/eof_decider.sv
module eof_decider
  import can_eof_pkg::*;
#(
  parameter int EOF_BITS   = 7,
  parameter int ACCEPT_BIT = 6,
  parameter int PW         = $clog2(EOF_BITS + 1)
) (
  input  logic          live,
  input  logic [PW-1:0] pos,
  input  logic          role_tx,
  input  logic          bit_rec,
  output eof_verdict_t  verdict
);

  localparam logic [PW-1:0] LastPos   = PW'(EOF_BITS);
  localparam logic [PW-1:0] AcceptPos = PW'(ACCEPT_BIT);

  always_comb begin
    verdict = '0;
    if (live) begin
      if (role_tx == ROLE_TX) begin
        // Transmitter: every bit of the field must be recessive.
        if (!bit_rec) begin
          verdict.tx_err = 1'b1;
          verdict.finish = 1'b1;
        end else if (pos == LastPos) begin
          verdict.done   = 1'b1;
          verdict.finish = 1'b1;
        end
      end else begin
        // Receiver: bits up to the validation point are checked.
        if (pos <= AcceptPos) begin
          if (!bit_rec) begin
            verdict.rx_err = 1'b1;
            verdict.finish = 1'b1;
          end else if (pos == AcceptPos) begin
            verdict.accept = 1'b1;
          end
        end
        if (pos == LastPos) verdict.finish = 1'b1;
      end
    end
  end

endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int W    = 8,
  parameter int STEP = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] value
);

  localparam logic [W:0] MaxVal = {1'b0, {W{1'b1}}};

  logic [W-1:0] cnt_q;
  logic [W:0]   sum;

  assign sum   = {1'b0, cnt_q} + (W + 1)'(STEP);
  assign value = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (inc) cnt_q <= (sum > MaxVal) ? MaxVal[W-1:0] : sum[W-1:0];
  end

endmodule

// File: rtl/can_eof_monitor.sv
module can_eof_monitor
  import can_eof_pkg::*;
#(
  parameter int EOF_BITS   = 7,
  parameter int ACCEPT_BIT = 6,
  parameter int REC_W      = 8,
  parameter int TEC_W      = 9,
  parameter int REC_STEP   = 1,
  parameter int TEC_STEP   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_valid_i,
  input  logic             bit_rec_i,
  input  logic             eof_start_i,
  input  logic             role_tx_i,
  output logic             rx_accept_o,
  output logic             tx_success_o,
  output logic             tx_retry_o,
  output logic             err_frame_o,
  output logic [REC_W-1:0] rec_o,
  output logic [TEC_W-1:0] tec_o,
  output logic             eof_active_o
);

  localparam int PW = $clog2(EOF_BITS + 1);

  logic          live;
  logic [PW-1:0] pos;
  logic          role_cur;
  eof_verdict_t  verdict;

  eof_tracker #(.EOF_BITS(EOF_BITS), .PW(PW)) u_tracker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_valid (bit_valid_i),
    .eof_start (eof_start_i),
    .role_in   (role_tx_i),
    .finish    (verdict.finish),
    .live      (live),
    .pos       (pos),
    .role_cur  (role_cur),
    .active    (eof_active_o)
  );

  eof_decider #(.EOF_BITS(EOF_BITS), .ACCEPT_BIT(ACCEPT_BIT), .PW(PW)) u_decider (
    .live    (live),
    .pos     (pos),
    .role_tx (role_cur),
    .bit_rec (bit_rec_i),
    .verdict (verdict)
  );

  sat_counter #(.W(REC_W), .STEP(REC_STEP)) u_rec (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (verdict.rx_err),
    .value (rec_o)
  );

  sat_counter #(.W(TEC_W), .STEP(TEC_STEP)) u_tec (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (verdict.tx_err),
    .value (tec_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_accept_o  <= 1'b0;
      tx_success_o <= 1'b0;
      tx_retry_o   <= 1'b0;
      err_frame_o  <= 1'b0;
    end else begin
      rx_accept_o  <= verdict.accept;
      tx_success_o <= verdict.done;
      tx_retry_o   <= verdict.tx_err;
      err_frame_o  <= verdict.rx_err | verdict.tx_err;
    end
  end

endmodule

// File: rtl/can_eof_monitor_chk.sv
module can_eof_monitor_chk #(
  parameter int REC_W    = 8,
  parameter int TEC_W    = 9,
  parameter int REC_STEP = 1,
  parameter int TEC_STEP = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_valid_i,
  input logic             eof_start_i,
  input logic             rx_accept_o,
  input logic             tx_success_o,
  input logic             tx_retry_o,
  input logic             err_frame_o,
  input logic [REC_W-1:0] rec_o,
  input logic [TEC_W-1:0] tec_o,
  input logic             eof_active_o
);

  localparam logic [REC_W-1:0] RecMax = {REC_W{1'b1}};
  localparam logic [TEC_W-1:0] TecMax = {TEC_W{1'b1}};

  p_one_outcome_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rx_accept_o, tx_success_o, tx_retry_o}) <= 1);

  p_accept_after_field_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_accept_o |-> $past(eof_active_o));

  p_no_strobe_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid_i |=> !(rx_accept_o || tx_success_o || tx_retry_o || err_frame_o));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!eof_active_o && !eof_start_i) |=> !(rx_accept_o || tx_success_o || err_frame_o));

  p_rec_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rec_o) |-> (err_frame_o && !tx_retry_o &&
                         rec_o == REC_W'($past(rec_o) + REC_W'(REC_STEP))));

  p_tec_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_retry_o |-> (err_frame_o &&
                    (tec_o == TEC_W'($past(tec_o) + TEC_W'(TEC_STEP)) || tec_o == TecMax)));

  p_rec_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_o == RecMax) |=> (rec_o == RecMax));

  p_tec_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tec_o == TecMax) |=> (tec_o == TecMax));

endmodule

bind can_eof_monitor can_eof_monitor_chk #(
  .REC_W(REC_W), .TEC_W(TEC_W), .REC_STEP(REC_STEP), .TEC_STEP(TEC_STEP)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bit_valid_i  (bit_valid_i),
  .eof_start_i  (eof_start_i),
  .rx_accept_o  (rx_accept_o),
  .tx_success_o (tx_success_o),
  .tx_retry_o   (tx_retry_o),
  .err_frame_o  (err_frame_o),
  .rec_o        (rec_o),
  .tec_o        (tec_o),
  .eof_active_o (eof_active_o)
);

// File: tb/tb_can_eof_monitor.sv
module tb_can_eof_monitor;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_valid_i = 1'b0;
  logic       bit_rec_i = 1'b1;
  logic       eof_start_i = 1'b0;
  logic       role_tx_i = 1'b0;
  logic       rx_accept_o, tx_success_o, tx_retry_o, err_frame_o, eof_active_o;
  logic [7:0] rec_o;
  logic [8:0] tec_o;

  int checks = 0;
  int failures = 0;
  int m_rec = 0;
  int m_tec = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  can_eof_monitor dut (
    .clk(clk), .rst_n(rst_n), .bit_valid_i(bit_valid_i), .bit_rec_i(bit_rec_i),
    .eof_start_i(eof_start_i), .role_tx_i(role_tx_i), .rx_accept_o(rx_accept_o),
    .tx_success_o(tx_success_o), .tx_retry_o(tx_retry_o), .err_frame_o(err_frame_o),
    .rec_o(rec_o), .tec_o(tec_o), .eof_active_o(eof_active_o)
  );

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Compare all outputs with the expected pulses, activity and model counters.
  task automatic check(input string tag, input bit a, input bit s, input bit e,
                       input bit r, input bit act);
    logic [4:0] got, exp;
    got = {rx_accept_o, tx_success_o, err_frame_o, tx_retry_o, eof_active_o};
    exp = {a, s, e, r, act};
    checks++;
    if (got !== exp || rec_o !== 8'(m_rec) || tec_o !== 9'(m_tec)) begin
      failures++;
      $display("FAIL %s: acc/succ/err/retry/act=%b rec=%0d tec=%0d, expected %b rec=%0d tec=%0d",
               tag, got, rec_o, tec_o, exp, m_rec, m_tec);
    end
  endtask

  // One strobed bit across exactly one rising edge; returns at the falling
  // edge where its registered results are visible.
  task automatic drive_bit(input bit start, input bit rec, input bit role);
    @(negedge clk);
    bit_valid_i = 1'b1; eof_start_i = start; bit_rec_i = rec; role_tx_i = role;
    @(negedge clk);
    bit_valid_i = 1'b0; eof_start_i = 1'b0; bit_rec_i = 1'b1;
  endtask

  // Seven strobes with a dominant level at dom_pos (0 = none); bits after the
  // field has ended are still sent and must be ignored.
  task automatic run_field(input bit role, input int dom_pos, input int gap);
    bit done = 1'b0;
    for (int k = 1; k <= 7; k++) begin
      bit rec = (k != dom_pos);
      bit a = 0, s = 0, e = 0, r = 0;
      string tag;
      if (done) tag = "R9";
      else if (!rec) begin
        done = 1'b1;
        if (role) begin
          e = 1; r = 1; tag = "R7";
          m_tec = (m_tec + 8 > 511) ? 511 : m_tec + 8;
        end else if (k <= 6) begin
          e = 1; tag = (k == 6) ? "R4" : "R2";
          m_rec = (m_rec + 1 > 255) ? 255 : m_rec + 1;
        end else tag = "R5";
      end else begin
        tag = role ? "R6" : "R3";
        if (!role && k == 6) a = 1;
        if (role && k == 7) s = 1;
        if (k == 7) done = 1'b1;
      end
      drive_bit(k == 1, rec, role);
      check(tag, a, s, e, r, !done);
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        check("R11", 0, 0, 0, 0, !done);
      end
    end
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog: run did not end, expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 0, 0, 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 0, 0, 0, 0, 0);

    // Exhaustive single-dominant sweep over both roles.
    for (int role = 0; role < 2; role++)
      for (int d = 0; d <= 7; d++)
        run_field(role[0], d, d % 3);

    // R10: restart mid-field with a new role.
    for (int k = 1; k <= 3; k++) begin
      drive_bit(k == 1, 1'b1, 1'b1);
      check("R10", 0, 0, 0, 0, 1);
    end
    for (int k = 1; k <= 7; k++) begin
      drive_bit(k == 1, 1'b1, 1'b0);
      check("R10", k == 6, 0, 0, 0, k != 7);
    end

    // R11: start flag without strobe does nothing.
    @(negedge clk);
    eof_start_i = 1'b1; role_tx_i = 1'b0;
    @(negedge clk);
    eof_start_i = 1'b0;
    check("R11", 0, 0, 0, 0, 0);

    // R8: drive both counters into saturation.
    for (int i = 0; i < 260; i++) run_field(1'b0, 1, 0);
    check("R8", 0, 0, 0, 0, 0);
    for (int i = 0; i < 70; i++) run_field(1'b1, 2, 0);
    check("R8", 0, 0, 0, 0, 0);
    if (m_rec != 255 || m_tec != 511) begin
      failures++;
      $display("FAIL R8: model rec=%0d tec=%0d, expected 255 511", m_rec, m_tec);
    end
    checks++;
    report();
  end

endmodule